// File: doc/BRIEF.md
# Encrypted Flash Region Decoder

This block sits on the flash read path, in front of an inline decryption unit. For every read address it decides, within the same cycle, whether the fetched word is ciphertext. If it is, the block also names the per-region key and IV context the decryption unit must use. The flash space is split into regions aligned to 256 KB. The first two regions span 256 KB each and the last spans 128 KB, for 640 KB in all. Each region is split into 8 KB sub-regions, and each sub-region carries its own enable bit. Software writes one enable mask per region through a small register port. A lock, once set, freezes those masks until the next reset.

The block also scrambles lines held in the flash cache. A mask word is taken from a random input port and XORed into data on cache fill and again on cache hit, so a hit returns the original word. The mask is handled by a two-state machine. `MSK_SEED` captures the random input on the next clock edge and always moves to `MSK_HOLD`. `MSK_HOLD` keeps the mask and returns to `MSK_SEED` when a reseed pulse arrives. Reset enters `MSK_SEED`.

The configuration side has a second two-state machine. `CFG_OPEN` accepts mask writes and moves to `CFG_LOCKED` on a write of 1 to bit 0 of the lock selector. `CFG_LOCKED` has no way out except reset. Reset enters `CFG_OPEN`.

Top module: `efr_decoder`

## Requirements
- R1: For an address below 0xA0000, address bits [19:18] give the region index (0, 1 or 2) on `region_idx`, and `region_valid` is high.
- R2: For a valid address, `dec_en` equals the bit of that region's enable mask selected by address bits [17:13]. `dec_en` is never high while `region_valid` is low.
- R3: An address at or above 0xA0000 gives `region_valid` low, `dec_en` low and `region_idx` 0.
- R4: `dec_en`, `region_idx` and `region_valid` follow `rd_addr` combinationally, with no clock edge between address and decision.
- R5: After reset all three enable masks are zero, the block is unlocked, and `cfg_rdata` reads zero on every selector.
- R6: A write with `cfg_sel` 0, 1 or 2 loads that region's mask from `cfg_wdata`, and the new mask is visible on `cfg_rdata` and in decoding from the next cycle. Bits [31:16] of region 2 always read zero.
- R7: A write with `cfg_sel` 3 and `cfg_wdata[0]`=1 sets the lock, which reads back on bit 0 of selector 3. From then until reset, mask writes are ignored and writing 0 to the lock does not clear it.
- R8: In the first cycle after reset release, `mask_rdy` is low. On the next clock edge the mask is taken from `rnd_in`, `mask_rdy` goes high, and `fill_out` equals `fill_in` XOR that value.
- R9: A `reseed` pulse while `mask_rdy` is high makes `mask_rdy` low after one edge. On the following edge a fresh value is captured from `rnd_in`, and `mask_rdy` goes high again.
- R10: While the mask is unchanged, `hit_out` equals `hit_in` XOR mask, so a word passed through `fill_out` and back through `hit_in` returns unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_addr | input | 20 | Flash read byte address |
| dec_en | output | 1 | Fetched word needs decryption |
| region_idx | output | 2 | Key/IV context to use |
| region_valid | output | 1 | Address lies inside an encryption region |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register selector: 0..2 region masks, 3 lock |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of selected register |
| rnd_in | input | 32 | Random word for the cache mask |
| reseed | input | 1 | Request a new cache mask |
| mask_rdy | output | 1 | Cache mask is settled |
| fill_in | input | 32 | Cache fill data, plain |
| fill_out | output | 32 | Cache fill data, masked |
| hit_in | input | 32 | Cache hit data, masked |
| hit_out | output | 32 | Cache hit data, unmasked |

## Verification
Decoding is tried with random masks and random addresses spread over the whole 1 MB space, so hits in all three regions and misses beyond the end are mixed. Directed addresses on the region edges (last byte of region 0, first of region 1, last valid byte, first invalid byte) separate an off-by-one in the field slicing from a wrong end limit for the short region. The lock is tried before and after setting, with clear attempts and overwrites, and the readback and decoding show whether a frozen mask leaked. The cache mask is checked at power-up, after a reseed, and on round trips of random data, which tells a wrong capture edge apart from a wrong XOR path.

// File: rtl/efr_pkg.sv
package efr_pkg;
    typedef enum logic {
        CFG_OPEN   = 1'b0,
        CFG_LOCKED = 1'b1
    } cfg_state_e;

    typedef enum logic {
        MSK_SEED = 1'b0,
        MSK_HOLD = 1'b1
    } msk_state_e;
endpackage

// File: rtl/efr_cfg_regs.sv
module efr_cfg_regs
    import efr_pkg::*;
#(
    parameter int NUM_REGIONS = 3,
    parameter int SUBS        = 32,
    parameter int LAST_SUBS   = 16,
    parameter int SEL_W       = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [SEL_W-1:0]                  cfg_sel,
    input  logic [SUBS-1:0]                   cfg_wdata,
    output logic [SUBS-1:0]                   cfg_rdata,
    output logic [NUM_REGIONS-1:0][SUBS-1:0]  region_mask,
    output logic                              locked
);
    localparam logic [SEL_W-1:0] LOCK_SEL = SEL_W'(NUM_REGIONS);

    cfg_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CFG_OPEN;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_OPEN: begin
                if (cfg_we && cfg_sel == LOCK_SEL && cfg_wdata[0])
                    state_d = CFG_LOCKED;
            end
            CFG_LOCKED: state_d = CFG_LOCKED;
            default:    state_d = CFG_OPEN;
        endcase
    end

    assign locked = (state_q == CFG_LOCKED);

    // one mask register per region, unimplemented sub-regions tied low
    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        localparam int IMPL = (r == NUM_REGIONS - 1) ? LAST_SUBS : SUBS;
        localparam logic [SUBS-1:0] KEEP = {SUBS{1'b1}} >> (SUBS - IMPL);
        logic [SUBS-1:0] mask_q;

        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_q <= '0;
            else if (state_q == CFG_OPEN && cfg_we && cfg_sel == SEL_W'(r))
                mask_q <= cfg_wdata & KEEP;
        end

        assign region_mask[r] = mask_q;
    end

    // readback
    always_comb begin
        cfg_rdata = '0;
        for (int r = 0; r < NUM_REGIONS; r++) begin
            if (cfg_sel == SEL_W'(r)) cfg_rdata = region_mask[r];
        end
        if (cfg_sel == LOCK_SEL) cfg_rdata = {{(SUBS-1){1'b0}}, locked};
    end
endmodule

// File: rtl/efr_addr_decode.sv
module efr_addr_decode #(
    parameter int NUM_REGIONS = 3,
    parameter int SUBS        = 32,
    parameter int LAST_SUBS   = 16,
    parameter int HI_W        = 2,
    parameter int SUB_W       = 5,
    parameter int RIDX_W      = 2
) (
    input  logic [HI_W-1:0]                   region_field,
    input  logic [SUB_W-1:0]                  sub_field,
    input  logic [NUM_REGIONS-1:0][SUBS-1:0]  region_mask,
    output logic                              dec_en,
    output logic [RIDX_W-1:0]                 region_idx,
    output logic                              region_valid
);
    localparam logic [HI_W:0]  N_REG    = (HI_W+1)'(NUM_REGIONS);
    localparam logic [HI_W:0]  LAST_REG = (HI_W+1)'(NUM_REGIONS - 1);
    localparam logic [SUB_W:0] LAST_LIM = (SUB_W+1)'(LAST_SUBS);

    logic            in_span;
    logic            short_ok;
    logic [SUBS-1:0] sel_mask;

    always_comb begin
        in_span  = ({1'b0, region_field} < N_REG);
        short_ok = ({1'b0, region_field} < LAST_REG) || ({1'b0, sub_field} < LAST_LIM);
        region_valid = in_span && short_ok;

        sel_mask = '0;
        for (int r = 0; r < NUM_REGIONS; r++) begin
            if (region_field == HI_W'(r)) sel_mask = region_mask[r];
        end

        dec_en     = region_valid && sel_mask[sub_field];
        region_idx = region_valid ? RIDX_W'(region_field) : '0;
    end
endmodule

// File: rtl/efr_cache_mask.sv
module efr_cache_mask
    import efr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rnd_in,
    input  logic              reseed,
    output logic              mask_rdy,
    output logic [DATA_W-1:0] cache_mask,
    input  logic [DATA_W-1:0] fill_in,
    output logic [DATA_W-1:0] fill_out,
    input  logic [DATA_W-1:0] hit_in,
    output logic [DATA_W-1:0] hit_out
);
    msk_state_e       state_q, state_d;
    logic [DATA_W-1:0] mask_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MSK_SEED;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MSK_SEED: state_d = MSK_HOLD;
            MSK_HOLD: if (reseed) state_d = MSK_SEED;
            default:  state_d = MSK_SEED;
        endcase
    end

    // mask capture
    always_ff @(posedge clk) begin
        if (!rst_n)                  mask_q <= '0;
        else if (state_q == MSK_SEED) mask_q <= rnd_in;
    end

    // outputs
    always_comb begin
        mask_rdy   = (state_q == MSK_HOLD);
        cache_mask = mask_q;
        fill_out   = fill_in ^ mask_q;
        hit_out    = hit_in ^ mask_q;
    end
endmodule

// File: rtl/efr_decoder.sv
module efr_decoder #(
    parameter int ADDR_W       = 20,
    parameter int REGION_SHIFT = 18,
    parameter int SUB_SHIFT    = 13,
    parameter int NUM_REGIONS  = 3,
    parameter int LAST_SUBS    = 16,
    parameter int DATA_W       = 32,
    localparam int SUBS        = 1 << (REGION_SHIFT - SUB_SHIFT),
    localparam int RIDX_W      = $clog2(NUM_REGIONS),
    localparam int SEL_W       = $clog2(NUM_REGIONS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              dec_en,
    output logic [RIDX_W-1:0] region_idx,
    output logic              region_valid,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [SUBS-1:0]   cfg_wdata,
    output logic [SUBS-1:0]   cfg_rdata,
    input  logic [DATA_W-1:0] rnd_in,
    input  logic              reseed,
    output logic              mask_rdy,
    input  logic [DATA_W-1:0] fill_in,
    output logic [DATA_W-1:0] fill_out,
    input  logic [DATA_W-1:0] hit_in,
    output logic [DATA_W-1:0] hit_out
);
    localparam int HI_W  = ADDR_W - REGION_SHIFT;
    localparam int SUB_W = REGION_SHIFT - SUB_SHIFT;

    logic [NUM_REGIONS-1:0][SUBS-1:0] region_mask;
    logic                             cfg_locked;
    logic [DATA_W-1:0]                cache_mask;
    logic                             unused_offset;

    assign unused_offset = ^rd_addr[SUB_SHIFT-1:0];

    efr_cfg_regs #(
        .NUM_REGIONS (NUM_REGIONS),
        .SUBS        (SUBS),
        .LAST_SUBS   (LAST_SUBS),
        .SEL_W       (SEL_W)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .region_mask (region_mask),
        .locked      (cfg_locked)
    );

    efr_addr_decode #(
        .NUM_REGIONS (NUM_REGIONS),
        .SUBS        (SUBS),
        .LAST_SUBS   (LAST_SUBS),
        .HI_W        (HI_W),
        .SUB_W       (SUB_W),
        .RIDX_W      (RIDX_W)
    ) u_dec (
        .region_field (rd_addr[ADDR_W-1:REGION_SHIFT]),
        .sub_field    (rd_addr[REGION_SHIFT-1:SUB_SHIFT]),
        .region_mask  (region_mask),
        .dec_en       (dec_en),
        .region_idx   (region_idx),
        .region_valid (region_valid)
    );

    efr_cache_mask #(
        .DATA_W (DATA_W)
    ) u_msk (
        .clk        (clk),
        .rst_n      (rst_n),
        .rnd_in     (rnd_in),
        .reseed     (reseed),
        .mask_rdy   (mask_rdy),
        .cache_mask (cache_mask),
        .fill_in    (fill_in),
        .fill_out   (fill_out),
        .hit_in     (hit_in),
        .hit_out    (hit_out)
    );
endmodule

// File: rtl/efr_decoder_chk.sv
module efr_decoder_chk #(
    parameter int ADDR_W       = 20,
    parameter int REGION_SHIFT = 18,
    parameter int SUB_SHIFT    = 13,
    parameter int NUM_REGIONS  = 3,
    parameter int LAST_SUBS    = 16,
    parameter int DATA_W       = 32,
    localparam int SUBS        = 1 << (REGION_SHIFT - SUB_SHIFT)
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [ADDR_W-1:0]                rd_addr,
    input logic                             dec_en,
    input logic                             region_valid,
    input logic                             reseed,
    input logic                             mask_rdy,
    input logic                             cfg_locked,
    input logic [NUM_REGIONS-1:0][SUBS-1:0] region_mask,
    input logic [DATA_W-1:0]                cache_mask
);
    localparam longint FLASH_END =
        longint'(NUM_REGIONS - 1) * (longint'(1) << REGION_SHIFT)
        + longint'(LAST_SUBS) * (longint'(1) << SUB_SHIFT);

    p_oob_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (longint'(rd_addr) >= FLASH_END) |-> (!dec_en && !region_valid));

    p_en_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_en |-> region_valid);

    p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_locked |=> cfg_locked);

    p_mask_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_locked |=> $stable(region_mask));

    p_seed_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_rdy |=> mask_rdy);

    p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_rdy && !reseed) |=> $stable(cache_mask));

    p_reseed_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_rdy && reseed) |=> !mask_rdy);
endmodule

bind efr_decoder efr_decoder_chk #(
    .ADDR_W       (ADDR_W),
    .REGION_SHIFT (REGION_SHIFT),
    .SUB_SHIFT    (SUB_SHIFT),
    .NUM_REGIONS  (NUM_REGIONS),
    .LAST_SUBS    (LAST_SUBS),
    .DATA_W       (DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_addr      (rd_addr),
    .dec_en       (dec_en),
    .region_valid (region_valid),
    .reseed       (reseed),
    .mask_rdy     (mask_rdy),
    .cfg_locked   (cfg_locked),
    .region_mask  (region_mask),
    .cache_mask   (cache_mask)
);

// File: tb/tb_efr_decoder.sv
module tb_efr_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [19:0] rd_addr;
    logic        dec_en;
    logic [1:0]  region_idx;
    logic        region_valid;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic [31:0] rnd_in;
    logic        reseed;
    logic        mask_rdy;
    logic [31:0] fill_in, fill_out, hit_in, hit_out;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] mdl [3];

    always #(CLK_PERIOD/2) clk = ~clk;

    efr_decoder dut (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .dec_en(dec_en),
        .region_idx(region_idx), .region_valid(region_valid),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .rnd_in(rnd_in), .reseed(reseed),
        .mask_rdy(mask_rdy), .fill_in(fill_in), .fill_out(fill_out),
        .hit_in(hit_in), .hit_out(hit_out)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic exp_valid(input logic [19:0] a);
        return (a[19:18] < 2'd2) || (a[19:18] == 2'd2 && a[17:13] < 5'd16);
    endfunction

    function automatic logic exp_en(input logic [19:0] a);
        return exp_valid(a) && mdl[a[19:18]][a[17:13]];
    endfunction

    task automatic check_addr(input logic [19:0] a);
        rd_addr = a;
        #1;
        check("R1 region", {62'd0, region_idx}, exp_valid(a) ? {62'd0, a[19:18]} : 64'd0);
        check("R3 valid", {63'd0, region_valid}, {63'd0, exp_valid(a)});
        check("R2 enable", {63'd0, dec_en}, {63'd0, exp_en(a)});
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, input logic [31:0] exp, input string req);
        cfg_sel = sel;
        #1;
        check(req, {32'd0, cfg_rdata}, {32'd0, exp});
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        logic [31:0] d;
        seed_dummy = $urandom(32'd20240611);
        rst_n = 1'b0; rd_addr = '0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        rnd_in = 32'hA5A5_0F0F; reseed = 1'b0; fill_in = '0; hit_in = '0;
        for (int r = 0; r < 3; r++) mdl[r] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R8: first cycle after release, mask not yet settled
        check("R8 rdy low", {63'd0, mask_rdy}, 64'd0);
        // R5: reset state
        for (int s = 0; s < 4; s++) rd(2'(s), 32'd0, "R5 readback");
        check_addr(20'h00000);
        check("R5 no decrypt", {63'd0, dec_en}, 64'd0);
        @(negedge clk);
        fill_in = 32'h1234_5678;
        #1;
        check("R8 rdy high", {63'd0, mask_rdy}, 64'd1);
        check("R8 fill mask", {32'd0, fill_out}, {32'd0, 32'h1234_5678 ^ 32'hA5A5_0F0F});

        // R6: program masks
        for (int r = 0; r < 3; r++) begin
            d = $urandom;
            wr(2'(r), d);
            mdl[r] = (r == 2) ? (d & 32'h0000_FFFF) : d;
            rd(2'(r), mdl[r], "R6 readback");
        end
        rd(2'd2, mdl[2] & 32'h0000_FFFF, "R6 region2 upper zero");

        // R1/R2/R3 directed edges
        check_addr(20'h3FFFF);
        check_addr(20'h40000);
        check_addr(20'h7FFFF);
        check_addr(20'h80000);
        check_addr(20'h9FFFF);
        check_addr(20'hA0000);
        check_addr(20'hFFFFF);
        check("R3 idx zero", {62'd0, region_idx}, 64'd0);

        // R4: decision follows address with no clock edge in between
        wr(2'd0, 32'h0000_0002); mdl[0] = 32'h0000_0002;
        @(posedge clk); #1;
        rd_addr = 20'h02000; #1;
        check("R4 same-cycle on", {63'd0, dec_en}, 64'd1);
        rd_addr = 20'h04000; #1;
        check("R4 same-cycle off", {63'd0, dec_en}, 64'd0);

        // random masks and addresses
        for (int r = 0; r < 3; r++) begin
            d = $urandom;
            wr(2'(r), d);
            mdl[r] = (r == 2) ? (d & 32'h0000_FFFF) : d;
        end
        for (int i = 0; i < 300; i++) check_addr(20'($urandom));

        // R7: lock
        wr(2'd3, 32'h0000_0000);
        rd(2'd3, 32'd0, "R7 lock clear bit0");
        wr(2'd3, 32'h0000_0001);
        rd(2'd3, 32'd1, "R7 lock set");
        wr(2'd0, ~mdl[0]);
        wr(2'd2, ~mdl[2]);
        rd(2'd0, mdl[0], "R7 region0 frozen");
        rd(2'd2, mdl[2], "R7 region2 frozen");
        wr(2'd3, 32'h0000_0000);
        rd(2'd3, 32'd1, "R7 lock sticky");
        for (int i = 0; i < 40; i++) check_addr(20'($urandom));

        // R9: reseed
        rnd_in = 32'h5EED_1234;
        @(negedge clk); reseed = 1'b1;
        @(negedge clk); reseed = 1'b0;
        #1;
        check("R9 rdy drop", {63'd0, mask_rdy}, 64'd0);
        @(negedge clk);
        fill_in = 32'h0F0F_F0F0;
        #1;
        check("R9 rdy back", {63'd0, mask_rdy}, 64'd1);
        check("R9 new mask", {32'd0, fill_out}, {32'd0, 32'h0F0F_F0F0 ^ 32'h5EED_1234});
        rnd_in = 32'hDEAD_BEEF;

        // R10: round trip
        for (int i = 0; i < 20; i++) begin
            d = $urandom;
            fill_in = d; #1;
            hit_in = fill_out; #1;
            check("R10 round trip", {32'd0, hit_out}, {32'd0, d});
            @(negedge clk);
        end

        // R5/R7: reset clears lock and masks
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(2'd3, 32'd0, "R7 unlocked after reset");
        for (int r = 0; r < 3; r++) begin
            mdl[r] = '0;
            rd(2'(r), 32'd0, "R5 mask cleared");
        end
        wr(2'd1, 32'h8000_0001); mdl[1] = 32'h8000_0001;
        rd(2'd1, 32'h8000_0001, "R6 write after reset");
        check_addr(20'h7E000);
        check_addr(20'h40000);

        summary();
        $finish;
    end
endmodule